// File: doc/BRIEF.md
# Sliding Two-Bit Parity Detector

This block watches a serial bit stream, one bit per clock when a valid strobe is high. It raises its output when the last two accepted bits contain an odd number of ones. The window moves forward by one bit on every accepted sample. Neighbouring pairs therefore share a bit, and every accepted bit produces a fresh result for the pair it forms with the bit before it.

The design is a four-state Moore machine. The state holds the earlier bit and the latest bit of the window. The output is decoded from the registered state alone, so the input never reaches the output within a cycle. A reset clears the state, which means the bit before the first accepted sample is taken as zero. The state is also driven out on a debug port.

Top module: `pair_parity_fsm`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) puts the state into 00 and drives parity_out to 0, whatever din and din_vld are.
- R2: On a rising edge with rst_n high and din_vld high, the state becomes {old present bit, din}. state_dbg[1] is the earlier bit and state_dbg[0] is the latest bit.
- R3: parity_out is 0 in states 00 and 11 and 1 in states 01 and 10.
- R4: parity_out depends only on the registered state. A change of din or din_vld between clock edges leaves parity_out unchanged until the next rising edge.
- R5: On a rising edge with rst_n high and din_vld low, state_dbg and parity_out keep their values.
- R6: Windows overlap. After reset, the accepted bits 0,1,0,0,1,1,0 give the outputs 0,1,1,0,1,0,1, one per accepted bit, after a reset output of 0.
- R7: The first bit accepted after a reset produces parity_out equal to that bit, because the bit before it is taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Serial data bit |
| din_vld | input | 1 | High when din is to be accepted at this edge |
| parity_out | output | 1 | Odd-parity flag of the two most recent accepted bits |
| state_dbg | output | 2 | Machine state as {earlier bit, latest bit} |

## Verification
The block has a window fixed at two bits, so the bench builds it with the package defaults. No parameter changes its behaviour. Because the state space is small, long random runs with gaps in the strobe and resets in mid-stream reach every state and every transition, including those taken right after reset. Directed steps cover the stated sample sequence and changes of din between clock edges.

// File: rtl/pair_parity_pkg.sv
// Shared types for the sliding two-bit parity machine.
// Assumes the window is exactly two bits; the state holds {earlier, latest}.
package pair_parity_pkg;
    localparam int WIN_BITS = 2;
    localparam int ST_W     = WIN_BITS;

    typedef enum logic [ST_W-1:0] {
        ST_00 = 2'b00,
        ST_01 = 2'b01,
        ST_10 = 2'b10,
        ST_11 = 2'b11
    } pp_state_t;
endpackage

// File: rtl/pp_next_state.sv
// Next-state logic: moves the window forward by one bit when a sample is accepted.
// Assumes the caller applies reset on its own; holds the state when vld is low.
module pp_next_state
    import pair_parity_pkg::*;
(
    input  pp_state_t cur_st,
    input  logic      bit_in,
    input  logic      vld,
    output pp_state_t nxt_st
);
    // Purpose: the latest bit becomes the earlier bit and the incoming bit becomes the latest.
    always_comb begin
        nxt_st = cur_st;
        if (vld) begin
            unique case (cur_st)
                ST_00, ST_10: nxt_st = bit_in ? ST_01 : ST_00;
                ST_01, ST_11: nxt_st = bit_in ? ST_11 : ST_10;
                default:      nxt_st = ST_00;
            endcase
        end
    end
endmodule

// File: rtl/pp_out_decode.sv
// Moore output decode: the parity flag for each state.
// Assumes its only input is the registered state, so there is no path from the input.
module pp_out_decode
    import pair_parity_pkg::*;
(
    input  pp_state_t st,
    output logic      odd
);
    // Purpose: flag the states whose two stored bits differ.
    always_comb begin
        unique case (st)
            ST_01, ST_10: odd = 1'b1;
            default:      odd = 1'b0;
        endcase
    end
endmodule

// File: rtl/pair_parity_fsm.sv
// Top level: a sliding two-bit odd-parity detector built as a Moore machine.
// Assumes one bit per clock when din_vld is high and a synchronous active-low reset.
module pair_parity_fsm
    import pair_parity_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din,
    input  logic            din_vld,
    output logic            parity_out,
    output logic [ST_W-1:0] state_dbg
);
    pp_state_t st_q;
    pp_state_t st_d;

    pp_next_state u_next (
        .cur_st (st_q),
        .bit_in (din),
        .vld    (din_vld),
        .nxt_st (st_d)
    );

    // Purpose: the state register, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_00;
        else        st_q <= st_d;
    end

    pp_out_decode u_dec (
        .st  (st_q),
        .odd (parity_out)
    );

    assign state_dbg = st_q;
endmodule

// File: rtl/pair_parity_fsm_chk.sv
// Checker for pair_parity_fsm; relates the ports across clock edges.
// Assumes it is attached by the bind statement at the end of this file.
module pair_parity_fsm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       din,
    input logic       din_vld,
    input logic       parity_out,
    input logic [1:0] state_dbg
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (state_dbg == 2'b00 && !parity_out)); // R1
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        din_vld |=> state_dbg == {$past(state_dbg[0]), $past(din)}); // R2
    AST_ODD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        parity_out == (state_dbg[1] ^ state_dbg[0])); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !din_vld |=> ($stable(state_dbg) && $stable(parity_out))); // R5
    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && din_vld) |=> parity_out == $past(din)); // R7
endmodule

bind pair_parity_fsm pair_parity_fsm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (din),
    .din_vld    (din_vld),
    .parity_out (parity_out),
    .state_dbg  (state_dbg)
);

// File: tb/pair_parity_fsm_bench.sv
// Self-checking bench: directed corner cases plus seeded random bursts.
module pair_parity_fsm_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic       din_vld = 1'b0;
    logic       parity_out;
    logic [1:0] state_dbg;

    int n_cmp = 0;
    int n_bad = 0;
    logic m_prev = 1'b0;
    logic m_cur  = 1'b0;

    always #4 clk = ~clk;

    pair_parity_fsm u_pair_parity_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .din_vld    (din_vld),
        .parity_out (parity_out),
        .state_dbg  (state_dbg)
    );

    function automatic logic exp_odd(input logic a, input logic b);
        return a ^ b;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rise, compare at the next fall.
    task automatic step(input logic r, input logic v, input logic d, input string req);
        rst_n = r; din_vld = v; din = d;
        @(posedge clk);
        if (!r) begin m_prev = 1'b0; m_cur = 1'b0; end
        else if (v) begin m_prev = m_cur; m_cur = d; end
        @(negedge clk);
        check({req, " state"}, state_dbg, {m_prev, m_cur});
        check({req, " out"}, {1'b0, parity_out}, {1'b0, exp_odd(m_prev, m_cur)});
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [6:0] seq;
        logic [6:0] want;
        logic held;
        @(negedge clk);
        // R1: reset with din and din_vld high
        step(1'b0, 1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, 1'b1, "R1");
        check("R1 reset out", {1'b0, parity_out}, 2'b00);
        // R6: sample sequence 0,1,0,0,1,1,0 -> 0,1,1,0,1,0,1
        seq  = 7'b0100110;
        want = 7'b0110101;
        for (int i = 6; i >= 0; i--) begin
            step(1'b1, 1'b1, seq[i], "R2");
            check("R6 sequence", {1'b0, parity_out}, {1'b0, want[i]});
        end
        // R3: walk through every state and check the decode
        step(1'b1, 1'b1, 1'b1, "R3"); // state 01
        step(1'b1, 1'b1, 1'b1, "R3"); // state 11
        check("R3 state 11", {1'b0, parity_out}, 2'b00);
        step(1'b1, 1'b1, 1'b0, "R3"); // state 10
        check("R3 state 10", {1'b0, parity_out}, 2'b01);
        // R5: idle cycles with din toggling hold the state
        held = parity_out;
        step(1'b1, 1'b0, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b0, "R5");
        check("R5 hold", {1'b0, parity_out}, {1'b0, held});
        // R4: change inputs between edges; output must not move
        held = parity_out;
        din = ~din; din_vld = 1'b1; #1;
        check("R4 moore", {1'b0, parity_out}, {1'b0, held});
        din = ~din; #1;
        check("R4 moore", {1'b0, parity_out}, {1'b0, held});
        // R7: reset in mid-stream then a 1 gives output 1
        step(1'b1, 1'b1, 1'b1, "R2");
        step(1'b0, 1'b1, 1'b1, "R1");
        step(1'b1, 1'b1, 1'b1, "R7");
        check("R7 first bit 1", {1'b0, parity_out}, 2'b01);
        step(1'b0, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b0, "R7");
        check("R7 first bit 0", {1'b0, parity_out}, 2'b00);
        // Random bursts with strobe gaps and occasional resets
        void'($urandom(32'd2024));
        for (int k = 0; k < 3000; k++) begin
            logic r, v, d;
            r = ($urandom % 50) != 0;
            v = ($urandom % 4) != 0;
            d = $urandom % 2;
            step(r, v, d, "R2/R3/R5 random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule